// File: doc/BRIEF.md
# Banked-Register Add Execution Unit

This block executes the two addition instructions of a small 8-bit accumulator core. One adds an 8-bit constant carried in the instruction to the working register W. The other adds W to a byte in a register file and sends the sum either to W or back to that byte. The block owns W, a bank select register and a five-flag status register. It drives a single read/write port toward a register file with a 12-bit address.

An instruction word arrives with a one-cycle valid strobe while `ready` is high. The unit then steps through four phases, one clock each:

- decode, which also fixes the file address;
- operand fetch;
- sum and flag computation;
- write-back.

`ready` is also high during write-back, so a new word can be accepted in that cycle and instructions can issue back to back.

The file address comes from one of two sources. In banked form it is the bank register joined to the 8-bit offset. In access form the lower offsets reach bank 0 and the upper offsets reach the top bank. When an external flag selects the extended mode, an access-form offset in the lower region is reported as an indexed request and is not executed. Any other opcode passes through the four phases and changes nothing.

Top module: `add_exec_unit`

## Requirements
- R1: After reset, W, the status register and the bank register read zero, `ready` is high, and `rf_re` and `rf_we` are low.
- R2: A word accepted on a clock edge (valid and ready both high) raises `done` in the fourth cycle after that edge. `ready` is high only when idle or during that write-back cycle. W and status show the result one cycle after `done`.
- R3: A word with bits [15:8] = 0x0F adds bits [7:0] to W, writes the sum to W and never accesses the register file.
- R4: A word with bits [15:10] = 001001 adds the file byte at the selected address to W. Bit 9 picks the destination: 0 writes W; 1 raises `rf_we` with `rf_wdata` equal to the sum in the `done` cycle and leaves W unchanged. The file is read (`rf_re`) only in the second phase.
- R5: Bit 8 picks the address source. When it is 1, the address is the bank register followed by bits [7:0]. When it is 0, offsets below 0x60 address bank 0 and offsets 0x60 and above address the all-ones bank.
- R6: The status layout is: bit 0 carry out of bit 7, bit 1 carry out of bit 3, bit 2 zero result, bit 3 signed overflow (equal-sign operands with a sum of the other sign), bit 4 result bit 7. Both add instructions update all five bits.
- R7: With `ext_mode` high, a register add with bit 8 = 0 and offset at most 0x5F raises `idx_hit` with `done`. It does no read and no write and leaves W and status unchanged. An offset of 0x60 or above executes normally.
- R8: A valid word matching neither opcode completes its four phases without touching W, status or the register file.
- R9: `bank_ld` loads `bank_din` into the bank register on the next edge. `bank_out` shows that value, and instructions decoded afterwards use it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction word strobe |
| instr_word | input | 16 | Instruction word |
| ext_mode | input | 1 | Extended indexed mode enable |
| bank_ld | input | 1 | Load bank register |
| bank_din | input | 4 | New bank register value |
| ready | output | 1 | Unit can accept a word this cycle |
| done | output | 1 | Write-back phase of an instruction |
| idx_hit | output | 1 | Indexed request reported (with done) |
| rf_addr | output | 12 | Register file address |
| rf_re | output | 1 | Register file read strobe |
| rf_rdata | input | 8 | Register file read data (same cycle) |
| rf_we | output | 1 | Register file write strobe |
| rf_wdata | output | 8 | Register file write data |
| w_out | output | 8 | Working register W |
| status_out | output | 5 | Status flags {N, OV, Z, DC, C} |
| bank_out | output | 4 | Bank select register |

## Verification
A phase register that skips or repeats a state shows at the ports within one instruction. It shifts `done` away from the fourth cycle after acceptance, or it moves the `rf_re` pulse out of the second phase. A wrong latched address or destination bit shows in the same instruction as a read or write at an unexpected address, or as a write strobe where W should change. A corrupted W or flag bit is only visible after write-back. It then carries into the sum and flags of every later instruction, so the next compared result exposes it.

// File: rtl/aeu_pkg.sv
package aeu_pkg;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_DEC  = 3'd1,
      PH_RD   = 3'd2,
      PH_EXE  = 3'd3,
      PH_WB   = 3'd4
   } phase_e;

   typedef enum logic [1:0] {
      OPK_NONE = 2'd0,
      OPK_LIT  = 2'd1,
      OPK_REG  = 2'd2
   } op_kind_e;

   localparam int          NFLAGS    = 5;
   localparam int          FL_C      = 0;
   localparam int          FL_DC     = 1;
   localparam int          FL_Z      = 2;
   localparam int          FL_OV     = 3;
   localparam int          FL_N      = 4;

   localparam logic [7:0]  LIT_OPC   = 8'h0F;
   localparam logic [5:0]  REG_OPC   = 6'b001001;

endpackage

// File: rtl/aeu_seq.sv
module aeu_seq
   import aeu_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   valid,
   output logic   ready,
   output logic   accept,
   output phase_e phase
);

   phase_e phase_q;
   phase_e phase_d;

   assign ready  = (phase_q == PH_IDLE) || (phase_q == PH_WB);
   assign accept = ready && valid;
   assign phase  = phase_q;

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_IDLE: phase_d = valid ? PH_DEC : PH_IDLE;
         PH_DEC:  phase_d = PH_RD;
         PH_RD:   phase_d = PH_EXE;
         PH_EXE:  phase_d = PH_WB;
         PH_WB:   phase_d = valid ? PH_DEC : PH_IDLE;
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= PH_IDLE;
      else        phase_q <= phase_d;
   end

   AST_DEC_TO_RD:  assert property (@(posedge clk) disable iff (!rst_n)
      phase_q == PH_DEC |=> phase_q == PH_RD);   // R2
   AST_RD_TO_EXE:  assert property (@(posedge clk) disable iff (!rst_n)
      phase_q == PH_RD |=> phase_q == PH_EXE);   // R2
   AST_EXE_TO_WB:  assert property (@(posedge clk) disable iff (!rst_n)
      phase_q == PH_EXE |=> phase_q == PH_WB);   // R2
   AST_ACCEPT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> phase_q == PH_DEC);             // R2

endmodule

// File: rtl/aeu_decode.sv
module aeu_decode
   import aeu_pkg::*;
#(
   parameter int         BANK_W       = 4,
   parameter int         ADDR_W       = BANK_W + 8,
   parameter logic [7:0] ACCESS_SPLIT = 8'h60
)(
   input  logic [15:0]       iword,
   input  logic [BANK_W-1:0] bank,
   input  logic              ext_mode,
   output op_kind_e          kind,
   output logic              to_file,
   output logic              indexed,
   output logic [ADDR_W-1:0] addr,
   output logic [7:0]        lit
);

   localparam logic [BANK_W-1:0] LOW_BANK = '0;
   localparam logic [BANK_W-1:0] TOP_BANK = '1;

   initial begin
      if (ADDR_W != BANK_W + 8)
         $fatal(1, "aeu_decode: ADDR_W must equal BANK_W + 8");
      if (ACCESS_SPLIT == 8'h00)
         $fatal(1, "aeu_decode: ACCESS_SPLIT must be nonzero");
   end

   logic              sel_bank;
   logic [7:0]        offs;
   logic [BANK_W-1:0] eff_bank;
   logic              low_region;

   assign offs       = iword[7:0];
   assign sel_bank   = iword[8];
   assign lit        = offs;
   assign low_region = offs < ACCESS_SPLIT;

   always_comb begin
      if (iword[15:8] == LIT_OPC)
         kind = OPK_LIT;
      else if (iword[15:10] == REG_OPC)
         kind = OPK_REG;
      else
         kind = OPK_NONE;
   end

   assign to_file = (kind == OPK_REG) && iword[9];
   assign indexed = (kind == OPK_REG) && ext_mode && !sel_bank && low_region;

   always_comb begin
      if (sel_bank)        eff_bank = bank;
      else if (low_region) eff_bank = LOW_BANK;
      else                 eff_bank = TOP_BANK;
   end

   assign addr = {eff_bank, offs};

endmodule

// File: rtl/aeu_alu.sv
module aeu_alu
   import aeu_pkg::*;
#(
   parameter int ALU_STYLE = 0
)(
   input  logic [7:0]        opa,
   input  logic [7:0]        opb,
   output logic [7:0]        sum,
   output logic [NFLAGS-1:0] flags
);

   initial begin
      if (ALU_STYLE < 0 || ALU_STYLE > 1)
         $fatal(1, "aeu_alu: ALU_STYLE must be 0 or 1");
   end

   logic c_out;
   logic dc_out;

   generate
      if (ALU_STYLE == 0) begin : g_nibble
         logic [4:0] lo5;
         logic [4:0] hi5;
         assign lo5    = {1'b0, opa[3:0]} + {1'b0, opb[3:0]};
         assign hi5    = {1'b0, opa[7:4]} + {1'b0, opb[7:4]} + {4'd0, lo5[4]};
         assign sum    = {hi5[3:0], lo5[3:0]};
         assign c_out  = hi5[4];
         assign dc_out = lo5[4];
      end else begin : g_flat
         logic [8:0] s9;
         logic [4:0] lo5;
         assign s9     = {1'b0, opa} + {1'b0, opb};
         assign lo5    = {1'b0, opa[3:0]} + {1'b0, opb[3:0]};
         assign sum    = s9[7:0];
         assign c_out  = s9[8];
         assign dc_out = lo5[4];
      end
   endgenerate

   always_comb begin
      flags         = '0;
      flags[FL_C]   = c_out;
      flags[FL_DC]  = dc_out;
      flags[FL_Z]   = (sum == 8'h00);
      flags[FL_OV]  = (opa[7] == opb[7]) && (sum[7] != opa[7]);
      flags[FL_N]   = sum[7];
   end

endmodule

// File: rtl/add_exec_unit.sv
module add_exec_unit
   import aeu_pkg::*;
#(
   parameter int         BANK_W       = 4,
   parameter int         ADDR_W       = BANK_W + 8,
   parameter logic [7:0] ACCESS_SPLIT = 8'h60,
   parameter int         ALU_STYLE    = 0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   input  logic [15:0]       instr_word,
   input  logic              ext_mode,
   input  logic              bank_ld,
   input  logic [BANK_W-1:0] bank_din,
   output logic              ready,
   output logic              done,
   output logic              idx_hit,
   output logic [ADDR_W-1:0] rf_addr,
   output logic              rf_re,
   input  logic [7:0]        rf_rdata,
   output logic              rf_we,
   output logic [7:0]        rf_wdata,
   output logic [7:0]        w_out,
   output logic [NFLAGS-1:0] status_out,
   output logic [BANK_W-1:0] bank_out
);

   initial begin
      if (BANK_W < 1 || BANK_W > 8)
         $fatal(1, "add_exec_unit: BANK_W out of range");
      if (ADDR_W != BANK_W + 8)
         $fatal(1, "add_exec_unit: ADDR_W must equal BANK_W + 8");
   end

   phase_e            phase;
   logic              accept;

   logic [15:0]       iword_q;
   logic              ext_q;
   logic [BANK_W-1:0] bank_q;
   logic [7:0]        w_q;
   logic [NFLAGS-1:0] st_q;

   op_kind_e          dk;
   logic              d_to_file, d_idx;
   logic [ADDR_W-1:0] d_addr;
   logic [7:0]        d_lit;

   op_kind_e          kind_q;
   logic              to_file_q, idx_q;
   logic [ADDR_W-1:0] addr_q;
   logic [7:0]        lit_q;
   logic [7:0]        opnd_q;
   logic [7:0]        res_q;
   logic [NFLAGS-1:0] fl_q;

   logic [7:0]        alu_sum;
   logic [NFLAGS-1:0] alu_fl;
   logic              executes;

   aeu_seq u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .valid  (instr_valid),
      .ready  (ready),
      .accept (accept),
      .phase  (phase)
   );

   aeu_decode #(
      .BANK_W       (BANK_W),
      .ADDR_W       (ADDR_W),
      .ACCESS_SPLIT (ACCESS_SPLIT)
   ) u_dec (
      .iword    (iword_q),
      .bank     (bank_q),
      .ext_mode (ext_q),
      .kind     (dk),
      .to_file  (d_to_file),
      .indexed  (d_idx),
      .addr     (d_addr),
      .lit      (d_lit)
   );

   aeu_alu #(.ALU_STYLE(ALU_STYLE)) u_alu (
      .opa   (w_q),
      .opb   (opnd_q),
      .sum   (alu_sum),
      .flags (alu_fl)
   );

   // capture the word and mode on acceptance
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iword_q <= '0;
         ext_q   <= 1'b0;
      end else if (accept) begin
         iword_q <= instr_word;
         ext_q   <= ext_mode;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       bank_q <= '0;
      else if (bank_ld) bank_q <= bank_din;
   end

   // phase 1: decode results are frozen for the rest of the instruction
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q    <= OPK_NONE;
         to_file_q <= 1'b0;
         idx_q     <= 1'b0;
         addr_q    <= '0;
         lit_q     <= '0;
      end else if (phase == PH_DEC) begin
         kind_q    <= dk;
         to_file_q <= d_to_file;
         idx_q     <= d_idx;
         addr_q    <= d_addr;
         lit_q     <= d_lit;
      end
   end

   // phase 2: operand fetch
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                opnd_q <= '0;
      else if (phase == PH_RD)   opnd_q <= (kind_q == OPK_REG) ? rf_rdata : lit_q;
   end

   // phase 3: compute
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q <= '0;
         fl_q  <= '0;
      end else if (phase == PH_EXE) begin
         res_q <= alu_sum;
         fl_q  <= alu_fl;
      end
   end

   assign executes = (kind_q != OPK_NONE) && !idx_q;

   // phase 4: write-back to W and status
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         w_q  <= '0;
         st_q <= '0;
      end else if (phase == PH_WB && executes) begin
         st_q <= fl_q;
         if (!to_file_q) w_q <= res_q;
      end
   end

   assign done       = (phase == PH_WB);
   assign idx_hit    = done && idx_q;
   assign rf_addr    = addr_q;
   assign rf_re      = (phase == PH_RD) && (kind_q == OPK_REG) && !idx_q;
   assign rf_we      = done && (kind_q == OPK_REG) && to_file_q && !idx_q;
   assign rf_wdata   = res_q;
   assign w_out      = w_q;
   assign status_out = st_q;
   assign bank_out   = bank_q;

   AST_READ_THEN_EXE: assert property (@(posedge clk) disable iff (!rst_n)
      rf_re |=> (phase == PH_EXE));                                  // R4
   AST_WADDR_STABLE:  assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> $stable(rf_addr));                                   // R5
   AST_LIT_NO_FILE:   assert property (@(posedge clk) disable iff (!rst_n)
      (done && kind_q == OPK_LIT) |-> !rf_we);                       // R3
   AST_IDX_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      idx_hit |=> ($stable(w_out) && $stable(status_out)));          // R7
   AST_NOP_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && kind_q == OPK_NONE) |=> ($stable(w_out) && $stable(status_out))); // R8
   AST_ZERO_FLAG:     assert property (@(posedge clk) disable iff (!rst_n)
      (done && executes && !to_file_q) |=> (status_out[FL_Z] == (w_out == 8'h00))); // R6
   AST_IDX_NO_WRITE:  assert property (@(posedge clk) disable iff (!rst_n)
      idx_hit |-> !rf_we);                                           // R7

endmodule

// File: tb/add_exec_unit_tb.sv
module add_exec_unit_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [15:0] instr_word = '0;
   logic        ext_mode = 1'b0;
   logic        bank_ld = 1'b0;
   logic [3:0]  bank_din = '0;
   logic        ready, done, idx_hit, rf_re, rf_we;
   logic [11:0] rf_addr;
   logic [7:0]  rf_rdata, rf_wdata, w_out;
   logic [4:0]  status_out;
   logic [3:0]  bank_out;

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [7:0] mem_val(input logic [11:0] a);
      return a[7:0] ^ {a[11:8], a[11:8]};
   endfunction

   assign rf_rdata = rf_re ? mem_val(rf_addr) : 8'h00;

   add_exec_unit u_dut (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
      .ext_mode(ext_mode), .bank_ld(bank_ld), .bank_din(bank_din), .ready(ready),
      .done(done), .idx_hit(idx_hit), .rf_addr(rf_addr), .rf_re(rf_re),
      .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_wdata(rf_wdata), .w_out(w_out),
      .status_out(status_out), .bank_out(bank_out)
   );

   typedef struct {
      logic        re;
      logic [11:0] addr;
      logic        we;
      logic [7:0]  wdata;
      logic        idx;
      logic [7:0]  w;
      logic [4:0]  st;
      int          issue;
      string       req;
   } exp_t;

   exp_t        q[$];
   int          n_chk = 0;
   int          n_bad = 0;
   int          cyc = 0;
   logic        mon_busy = 1'b0;
   logic        seen_re = 1'b0;
   logic [7:0]  m_w = '0;
   logic [4:0]  m_st = '0;
   logic [3:0]  m_bank = '0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input logic ok, input string req, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic run(input logic [15:0] iw, input logic ext, input string req);
      exp_t e;
      logic is_lit, is_reg, d, a;
      logic [7:0] f, opnd, s;
      logic [8:0] s9;
      is_lit = iw[15:8] == 8'h0F;
      is_reg = iw[15:10] == 6'b001001;
      d = iw[9]; a = iw[8]; f = iw[7:0];
      e.req  = req;
      e.idx  = is_reg && ext && !a && (f <= 8'h5F);
      e.addr = a ? {m_bank, f} : ((f < 8'h60) ? {4'h0, f} : {4'hF, f});
      e.re   = is_reg && !e.idx;
      opnd   = is_lit ? f : mem_val(e.addr);
      s9     = {1'b0, m_w} + {1'b0, opnd};
      s      = s9[7:0];
      e.we   = is_reg && d && !e.idx;
      e.wdata = s;
      if ((is_lit || is_reg) && !e.idx) begin
         m_st = {s[7], (m_w[7] == opnd[7]) && (s[7] != m_w[7]), s == 8'h00,
                 ({1'b0, m_w[3:0]} + {1'b0, opnd[3:0]}) > 5'h0F, s9[8]};
         if (!(is_reg && d)) m_w = s;
      end
      e.w  = m_w;
      e.st = m_st;
      @(negedge clk);
      while (!ready) @(negedge clk);
      ext_mode    = ext;
      instr_word  = iw;
      instr_valid = 1'b1;
      e.issue     = cyc;
      q.push_back(e);
      @(negedge clk);
      instr_valid = 1'b0;
      wait (q.size() == 0 && !mon_busy);
   endtask

   task automatic load_bank(input logic [3:0] v);
      @(negedge clk);
      bank_ld  = 1'b1;
      bank_din = v;
      @(negedge clk);
      bank_ld  = 1'b0;
      m_bank   = v;
      chk(bank_out == v, "R9", "bank_out", {12'd0, bank_out}, {12'd0, v});
   endtask

   // monitor / scoreboard
   initial begin
      exp_t h;
      forever begin
         @(negedge clk);
         if (rf_re) begin
            if (q.size() == 0 || !q[0].re)
               chk(1'b0, "R4", "unexpected rf_re", {4'd0, rf_addr}, 16'h0);
            else begin
               chk(rf_addr == q[0].addr, "R5", "read address", {4'd0, rf_addr}, {4'd0, q[0].addr});
               seen_re = 1'b1;
            end
         end
         if (!done && rf_we)
            chk(1'b0, "R4", "rf_we outside write-back", 16'h1, 16'h0);
         if (done) begin
            if (q.size() == 0) begin
               chk(1'b0, "R2", "done with nothing issued", 16'h1, 16'h0);
            end else begin
               mon_busy = 1'b1;
               h = q.pop_front();
               chk(cyc - h.issue == 4, "R2", "done latency", 16'(cyc - h.issue), 16'd4);
               chk(seen_re == h.re, {h.req, "/R4"}, "read performed", {15'd0, seen_re}, {15'd0, h.re});
               chk(idx_hit == h.idx, {h.req, "/R7"}, "idx_hit", {15'd0, idx_hit}, {15'd0, h.idx});
               chk(rf_we == h.we, {h.req, "/R4"}, "rf_we", {15'd0, rf_we}, {15'd0, h.we});
               if (h.we) begin
                  chk(rf_wdata == h.wdata, {h.req, "/R4"}, "rf_wdata", {8'd0, rf_wdata}, {8'd0, h.wdata});
                  chk(rf_addr == h.addr, {h.req, "/R5"}, "write address", {4'd0, rf_addr}, {4'd0, h.addr});
               end
               seen_re = 1'b0;
               @(negedge clk);
               chk(w_out == h.w, h.req, "W", {8'd0, w_out}, {8'd0, h.w});
               chk(status_out == h.st, {h.req, "/R6"}, "status", {11'd0, status_out}, {11'd0, h.st});
               mon_busy = 1'b0;
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(w_out == 8'h00, "R1", "W after reset", {8'd0, w_out}, 16'h0);
      chk(status_out == 5'h00, "R1", "status after reset", {11'd0, status_out}, 16'h0);
      chk(bank_out == 4'h0, "R1", "bank after reset", {12'd0, bank_out}, 16'h0);
      chk(ready == 1'b1, "R1", "ready after reset", {15'd0, ready}, 16'h1);
      chk(!rf_re && !rf_we, "R1", "no file access after reset", {14'd0, rf_re, rf_we}, 16'h0);

      run(16'h0F10, 1'b0, "R3");              // W = 10
      run(16'h0F15, 1'b0, "R3");              // W = 25
      run(16'h0FF2, 1'b0, "R3");              // W = 17, carry
      run(16'h25C2, 1'b0, "R4");              // banked 0C2: W = D9
      load_bank(4'h5);
      run(16'h2733, 1'b0, "R4");              // d=1 to file 533
      run(16'h2420, 1'b0, "R5");              // access low -> 020
      run(16'h2480, 1'b0, "R5");              // access high -> F80
      run(16'h0F00 | {8'h00, 8'h00 - m_w}, 1'b0, "R6"); // zero with carry
      run(16'h0F7F, 1'b0, "R6");
      run(16'h0F01, 1'b0, "R6");              // 7F+1 overflow
      run(16'h0F88, 1'b0, "R6");              // neg+neg overflow
      run(16'h2440, 1'b1, "R7");              // indexed request
      run(16'h265F, 1'b1, "R7");              // boundary 5F, d=1
      run(16'h2460, 1'b1, "R7");              // 60 executes normally
      run(16'h2510, 1'b1, "R7");              // banked unaffected
      run(16'h1234, 1'b0, "R8");
      run(16'h0E05, 1'b0, "R8");
      run(16'h2B10, 1'b0, "R8");
      load_bank(4'hA);
      run(16'h2577, 1'b0, "R9");              // uses bank A
      repeat (3) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule